// File: doc/BRIEF.md
# Flow-Through No-Wait Burst SRAM

This block is a synthesizable behavioural model of a synchronous static RAM. It has flow-through reads and writes that need no turnaround gap. Address, command, byte-write enables and burst order are captured on the rising clock edge. A read returns data during the cycle that follows the capturing edge, with no output register. Write data is pipelined by one cycle: the bus carries it during the cycle after the write command, and it is committed on the next enabled edge. Because of this, a read and a write can follow each other on consecutive cycles in either direction. The array is kept small so that it can be simulated.

A load cycle starts a read, a write or a deselect. Advance cycles then step a 2-bit burst counter. The counter walks four words, either in linear (wrapping add) order or in interleaved (XOR) order, and the upper address bits stay fixed. A clock-hold input freezes the whole block. Three chip selects of mixed polarity are provided for depth expansion. A sleep input forces the bus quiet and blocks commands, while the array keeps its contents.

The common data bus is split into `dataIn`, `dataOut` and the drive enable `dataOutEn`. A low `dataOutEn` stands for high impedance.

Top module: `nowait_burst_sram`

## Requirements
- R1: After reset the block is idle and `dataOutEn` is 0.
- R2: At an edge where `holdClk` is 1, every input is ignored. Command, burst position, pending write and output data all keep their values, including in the middle of a read or write burst.
- R3: At an edge with `loadN`=0, a new command and address are taken. With `loadN`=1, the burst counter steps by one and the current command type continues. Read data for the current burst address appears in the cycle after the edge.
- R4: A burst loaded with `burstInterleave`=0 visits offset (start + n) mod 4, where start is `addr[1:0]`. Address bits above bit 1 stay fixed, so the fifth beat returns to the start.
- R5: A burst loaded with `burstInterleave`=1 visits offset start XOR (n mod 4).
- R6: Write data for a beat is taken from `dataIn` on the edge after the edge that made that beat current. Lane i is bits [9i+8:9i], with its parity bit at the top of the lane. The lane is written only if `byteWrN[i]` was 0 at the beat's command edge.
- R7: A read loaded on the cycle right after a write to the same address returns the new data. A write may be loaded right after a read with no idle cycle. `dataOutEn` is 0 while a write is current.
- R8: The block is selected only when `selA_n`=0, `selB`=1 and `selC_n`=0. A load with any select inactive is a deselect: `dataOutEn` goes to 0, and advance cycles have no effect until the next selected load.
- R9: `dataOutEn` is 1 only while a read is current, `outEnN` is 0 and `sleep` is 0. `outEnN` acts without a clock.
- R10: While `sleep` is 1, `dataOutEn` is 0 and load commands are ignored, so that any burst ends. The memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| holdClk | input | 1 | 1 = suspend: the edge is ignored |
| selA_n | input | 1 | Chip select, active low |
| selB | input | 1 | Chip select, active high |
| selC_n | input | 1 | Chip select, active low |
| loadN | input | 1 | 0 = load new command, 1 = advance burst |
| writeN | input | 1 | 0 = write, 1 = read (at load) |
| byteWrN | input | LANES | Per-lane write enables, active low |
| outEnN | input | 1 | Output enable, active low |
| burstInterleave | input | 1 | 1 = interleaved order, 0 = linear (at load) |
| sleep | input | 1 | 1 = outputs off, commands blocked |
| addr | input | ADDR_W | Word address |
| dataIn | input | LANES*LANE_W | Write data bus |
| dataOut | output | LANES*LANE_W | Read data (0 when not driven) |
| dataOutEn | output | 1 | 1 = block drives the bus |

## Verification
The sweeps run both burst orders from all four start offsets and run past the wrap. A counter that carried into the upper address bits, or that mixed up add and XOR, would return a neighbouring word. Byte-lane masks change on every beat of a write burst. A lane enable sampled at the wrong beat, or a parity bit left outside its lane, would corrupt a lane in the read-back. Write-then-read pairs on one address catch write data committed one edge late, which would return the old data. Holds inserted during read and write bursts catch a counter that steps or a write that commits on a suspended edge. Deselects, output-enable toggles and sleep catch a bus that drives when it should not, and an advance that revives a burst that has ended.

// File: rtl/nwb_pkg.sv
package nwb_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } opE;

  typedef struct packed {
    logic wrCommit;
    logic rdActive;
  } ctlStrobes;
endpackage

// File: rtl/nwb_ctrl.sv
module nwb_ctrl
  import nwb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              holdClk,
  input  logic              selA_n,
  input  logic              selB,
  input  logic              selC_n,
  input  logic              loadN,
  input  logic              writeN,
  input  logic [LANES-1:0]  byteWrN,
  input  logic              burstInterleave,
  input  logic              sleep,
  input  logic [ADDR_W-1:0] addr,
  output ctlStrobes         strobes,
  output logic [ADDR_W-1:0] curAddr,
  output logic [LANES-1:0]  laneEn
);
  localparam int HI_W = ADDR_W - 2;

  opE              opReg;
  logic [HI_W-1:0] baseHi;
  logic [1:0]      startOff;
  logic [1:0]      beatCnt;
  logic            orderIl;
  logic [LANES-1:0] laneReg;
  logic            chipOn;
  logic [1:0]      beatOff;

  assign chipOn = !selA_n && selB && !selC_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opReg    <= OP_IDLE;
      baseHi   <= '0;
      startOff <= '0;
      beatCnt  <= '0;
      orderIl  <= 1'b0;
      laneReg  <= '0;
    end else if (!holdClk) begin
      if (sleep) begin
        opReg <= OP_IDLE;
      end else if (!loadN) begin
        if (chipOn) begin
          opReg    <= writeN ? OP_READ : OP_WRITE;
          baseHi   <= addr[ADDR_W-1:2];
          startOff <= addr[1:0];
          beatCnt  <= 2'd0;
          orderIl  <= burstInterleave;
          laneReg  <= ~byteWrN;
        end else begin
          opReg <= OP_IDLE;
        end
      end else if (opReg != OP_IDLE) begin
        beatCnt <= beatCnt + 2'd1;
        laneReg <= ~byteWrN;
      end
    end
  end

  assign beatOff          = orderIl ? (startOff ^ beatCnt) : (startOff + beatCnt);
  assign curAddr          = {baseHi, beatOff};
  assign laneEn           = laneReg;
  assign strobes.wrCommit = (opReg == OP_WRITE) && !holdClk;
  assign strobes.rdActive = (opReg == OP_READ);

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    holdClk |=> ($stable(curAddr) && opReg == $past(opReg))); // R2

  AST_ADVANCE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (loadN && !holdClk && !sleep && opReg != OP_IDLE) |=> (beatCnt == $past(beatCnt) + 2'd1)); // R3

  AST_BURST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (loadN && !holdClk && !sleep && opReg != OP_IDLE) |=> (curAddr[ADDR_W-1:2] == $past(curAddr[ADDR_W-1:2]))); // R4

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!loadN && !holdClk && !sleep && !chipOn) |=> (opReg == OP_IDLE)); // R8

  AST_SLEEP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !holdClk) |=> (opReg == OP_IDLE)); // R10
endmodule

// File: rtl/nwb_datapath.sv
module nwb_datapath
  import nwb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ctlStrobes               strobes,
  input  logic [ADDR_W-1:0]       curAddr,
  input  logic [LANES-1:0]        laneEn,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  logic                    outEnN,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataOutEn
);
  localparam int DEPTH = 1 << ADDR_W;

  assign dataOutEn = strobes.rdActive && !outEnN && !sleep;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (strobes.wrCommit && laneEn[l])
        laneMem[curAddr] <= dataIn[l*LANE_W +: LANE_W];
    end

    assign dataOut[l*LANE_W +: LANE_W] = dataOutEn ? laneMem[curAddr] : '0;
  end

  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.wrCommit |-> !dataOutEn); // R7
endmodule

// File: rtl/nowait_burst_sram.sv
module nowait_burst_sram
  import nwb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    holdClk,
  input  logic                    selA_n,
  input  logic                    selB,
  input  logic                    selC_n,
  input  logic                    loadN,
  input  logic                    writeN,
  input  logic [LANES-1:0]        byteWrN,
  input  logic                    outEnN,
  input  logic                    burstInterleave,
  input  logic                    sleep,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataOutEn
);
  ctlStrobes         strobes;
  logic [ADDR_W-1:0] curAddr;
  logic [LANES-1:0]  laneEn;

  nwb_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .holdClk(holdClk),
    .selA_n(selA_n), .selB(selB), .selC_n(selC_n),
    .loadN(loadN), .writeN(writeN), .byteWrN(byteWrN),
    .burstInterleave(burstInterleave), .sleep(sleep), .addr(addr),
    .strobes(strobes), .curAddr(curAddr), .laneEn(laneEn)
  );

  nwb_datapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .curAddr(curAddr),
    .laneEn(laneEn), .dataIn(dataIn), .outEnN(outEnN), .sleep(sleep),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );
endmodule

// File: tb/nowait_burst_sram_bench.sv
module nowait_burst_sram_bench;
  localparam int AW = 6;
  localparam int L  = 2;
  localparam int LW = 9;
  localparam int DW = L * LW;
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] SEL_ON = 3'b010;  // {selA_n, selB, selC_n}

  logic clk = 1'b0;
  logic rst_n, holdClk, selA_n, selB, selC_n, loadN, writeN, outEnN, burstInterleave, sleep;
  logic [L-1:0]  byteWrN;
  logic [AW-1:0] addr;
  logic [DW-1:0] dataIn, dataOut;
  logic          dataOutEn;

  logic [DW-1:0] refMem [DEPTH];
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  nowait_burst_sram #(.ADDR_W(AW), .LANES(L), .LANE_W(LW)) u_nowait_burst_sram (
    .clk(clk), .rst_n(rst_n), .holdClk(holdClk), .selA_n(selA_n), .selB(selB),
    .selC_n(selC_n), .loadN(loadN), .writeN(writeN), .byteWrN(byteWrN),
    .outEnN(outEnN), .burstInterleave(burstInterleave), .sleep(sleep),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'((a * 2654 + salt * 977 + 13) ^ (a << 9) ^ (salt << 13));
  endfunction

  function automatic logic [DW-1:0] mergeLanes(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                                input logic [L-1:0] bwN);
    logic [DW-1:0] r = old;
    for (int l = 0; l < L; l++)
      if (!bwN[l]) r[l*LW +: LW] = nw[l*LW +: LW];
    return r;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle after a falling edge; returns at the next falling edge.
  task automatic tick(input logic ld, input logic wr, input logic [2:0] sel, input logic [AW-1:0] a,
                      input logic [L-1:0] bw, input logic il, input logic [DW-1:0] d);
    loadN = ld; writeN = wr; {selA_n, selB, selC_n} = sel; addr = a;
    byteWrN = bw; burstInterleave = il; dataIn = d;
    @(negedge clk);
  endtask

  function automatic logic [1:0] offOf(input logic [1:0] st, input int n, input logic il);
    return il ? (st ^ 2'(n)) : (st + 2'(n));
  endfunction

  task automatic readBurst(input logic [AW-3:0] base, input logic [1:0] st, input logic il, input int beats);
    for (int n = 0; n < beats; n++) begin
      logic [AW-1:0] ea = {base, offOf(st, n, il)};
      tick(n == 0 ? 1'b0 : 1'b1, 1'b1, SEL_ON, {base, st}, '1, il, '0);
      check(il ? "R5 drive" : "R4 drive", DW'(dataOutEn), DW'(1));
      check(il ? "R5 interleaved beat" : "R4 linear beat", dataOut, refMem[ea]);
    end
  endtask

  // R6: per-beat lane masks, data one cycle behind the command edge
  task automatic writeBurst(input logic [AW-3:0] base, input logic [1:0] st, input logic il, input int salt);
    logic [DW-1:0] d;
    tick(1'b0, 1'b0, SEL_ON, {base, st}, L'(0), il, '0);
    for (int n = 0; n < 4; n++) begin
      logic [AW-1:0] ea = {base, offOf(st, n, il)};
      d = pat(ea, salt);
      if (n < 3) tick(1'b1, 1'b0, SEL_ON, '0, L'(n + 1), il, d);
      else       tick(1'b0, 1'b1, 3'b110, '0, '1, il, d);
      refMem[ea] = mergeLanes(refMem[ea], d, L'(n));
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; holdClk = 1'b0; outEnN = 1'b0; sleep = 1'b0;
    loadN = 1'b0; writeN = 1'b1; {selA_n, selB, selC_n} = 3'b110;
    byteWrN = '1; burstInterleave = 1'b0; addr = '0; dataIn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", DW'(dataOutEn), DW'(0));

    // Fill with back-to-back writes (R7 write-to-write pipelining)
    for (int a = 0; a <= DEPTH; a++) begin
      if (a < DEPTH) tick(1'b0, 1'b0, SEL_ON, AW'(a), '0, 1'b0, a == 0 ? '0 : pat(a - 1, 1));
      else           tick(1'b0, 1'b1, 3'b110, '0, '1, 1'b0, pat(a - 1, 1));
      if (a > 0) refMem[a - 1] = pat(a - 1, 1);
    end

    // Both orders from every start offset, five beats to show the wrap (R4, R5, R3)
    for (int il = 0; il < 2; il++)
      for (int st = 0; st < 4; st++)
        readBurst(AW'(il * 4 + st) >> 0, 2'(st), il[0], 5);

    // Partial-lane write bursts read back in both orders (R6)
    for (int il = 0; il < 2; il++)
      for (int st = 0; st < 4; st++) begin
        writeBurst((AW-2)'(8 + il * 4 + st), 2'(st), il[0], 7 + st);
        readBurst((AW-2)'(8 + il * 4 + st), 2'(st), ~il[0], 4);
      end

    // Alternating write and read on one address, no gap either way (R7)
    for (int k = 0; k < 8; k++) begin
      logic [AW-1:0] a = AW'(33 + k * 3);
      logic [DW-1:0] d = pat(a, 40 + k);
      tick(1'b0, 1'b0, SEL_ON, a, '0, 1'b0, '0);
      check("R7 no drive during write", DW'(dataOutEn), DW'(0));
      tick(1'b0, 1'b1, SEL_ON, a, '1, 1'b0, d);
      refMem[a] = d;
      check("R7 read after write", dataOut, d);
    end
    tick(1'b0, 1'b1, 3'b110, '0, '1, 1'b0, '0);

    // Hold in a read burst (R2)
    tick(1'b0, 1'b1, SEL_ON, {4'd5, 2'd1}, '1, 1'b0, '0);
    check("R2 beat0", dataOut, refMem[{4'd5, 2'd1}]);
    holdClk = 1'b1;
    tick(1'b0, 1'b0, SEL_ON, 6'd60, '0, 1'b1, '1);
    check("R2 hold keeps drive", DW'(dataOutEn), DW'(1));
    check("R2 hold keeps data", dataOut, refMem[{4'd5, 2'd1}]);
    holdClk = 1'b0;
    tick(1'b1, 1'b1, SEL_ON, '0, '1, 1'b0, '0);
    check("R2 advance after hold", dataOut, refMem[{4'd5, 2'd2}]);

    // Hold while write data is pending (R2, R6)
    tick(1'b0, 1'b0, SEL_ON, 6'd50, '0, 1'b0, '0);
    holdClk = 1'b1;
    tick(1'b0, 1'b1, SEL_ON, 6'd3, '1, 1'b0, ~pat(50, 90));
    holdClk = 1'b0;
    tick(1'b0, 1'b1, SEL_ON, 6'd50, '1, 1'b0, pat(50, 90));
    refMem[50] = pat(50, 90);
    check("R2 write data after hold", dataOut, pat(50, 90));

    // Deselect through each select, then an advance (R8)
    for (int s = 0; s < 3; s++) begin
      logic [2:0] bad = SEL_ON ^ (3'b100 >> s);
      tick(1'b0, 1'b1, SEL_ON, 6'd20, '1, 1'b0, '0);
      check("R8 selected read", dataOut, refMem[20]);
      tick(1'b0, 1'b1, bad, 6'd21, '1, 1'b0, '0);
      check("R8 deselect off", DW'(dataOutEn), DW'(0));
      tick(1'b1, 1'b1, SEL_ON, 6'd22, '1, 1'b0, '0);
      check("R8 advance after deselect", DW'(dataOutEn), DW'(0));
    end

    // Output enable (R9)
    outEnN = 1'b1;
    tick(1'b0, 1'b1, SEL_ON, 6'd7, '1, 1'b0, '0);
    check("R9 oe high off", DW'(dataOutEn), DW'(0));
    outEnN = 1'b0; #1;
    check("R9 oe low drive", DW'(dataOutEn), DW'(1));
    check("R9 oe low data", dataOut, refMem[7]);

    // Sleep (R10)
    @(negedge clk);
    sleep = 1'b1; #1;
    check("R10 sleep off", DW'(dataOutEn), DW'(0));
    tick(1'b0, 1'b0, SEL_ON, 6'd7, '0, 1'b0, '0);
    tick(1'b1, 1'b0, SEL_ON, 6'd7, '0, 1'b0, ~refMem[7]);
    check("R10 sleep still off", DW'(dataOutEn), DW'(0));
    sleep = 1'b0;
    tick(1'b1, 1'b1, SEL_ON, 6'd7, '1, 1'b0, ~refMem[7]);
    check("R10 burst ended by sleep", DW'(dataOutEn), DW'(0));
    tick(1'b0, 1'b1, SEL_ON, 6'd7, '1, 1'b0, '0);
    check("R10 contents kept", dataOut, refMem[7]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule